// File: doc/BRIEF.md
# Quality-Graded Timing Reference Selector

This block chooses one active timing reference out of a small set of candidate inputs (for example a satellite receiver pulse, a network-recovered clock and a bench frequency standard). Each input arrives with a valid flag and a quality grade, and software supplies a rank per input together with a hysteresis margin, a hold-off length and a minimum spacing between switches. The block compares the grades and moves to a better reference only once the improvement is clear and has lasted, so that marginal or jittery quality reports do not make it flap.

Losing the active reference forces a prompt move to the best remaining input, limited only by the switch spacing. A manual override pins a chosen input while that input is valid. Every switch raises a one-cycle strobe and an event carrying a reason code, and a switch that is wanted but held back by the spacing rule is reported once as a deferral. When no input is valid the block raises a no-reference flag and keeps its last choice.

Top module: `ref_selector`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `active_sel` is 0 and `switch_stb` and `evt_valid` are 0.
- R2: The best candidate is the valid input with the highest `in_qual` value; equal grades go to the lower `in_rank` value, and equal ranks to the lower input index.
- R3: A valid active input is displaced for quality only when the best candidate's grade exceeds the active grade by strictly more than `hyst_margin`.
- R4: A quality-driven switch happens at the clock edge where the R3 condition, with the same candidate, has been seen on `holdoff_cyc`+1 consecutive edges; the switch is reported with reason code 2.
- R5: When the active input is invalid and some other input is valid, the block moves to the best candidate without waiting for the hold-off, reporting reason code 1.
- R6: Two switches are never closer than `min_gap_cyc` clock cycles; a switch held back by this rule produces exactly one event with reason code 4 and no strobe, and the switch happens once the spacing allows.
- R7: With `force_en` high and input `force_sel` valid, the block switches to that input (reason code 3, spacing still applied) and makes no automatic switch; if the forced input is invalid, the automatic rules apply.
- R8: When no input is valid, `no_ref` is 1, `active_sel` does not change and no switch occurs; otherwise `no_ref` is 0.
- R9: Every `switch_stb` pulse coincides with `evt_valid` and a reason code of 1, 2 or 3; outputs change one cycle after the deciding edge's inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | N_IN | Per-input valid flags |
| in_qual | input | N_IN*QW | Per-input quality grade, higher is better, input i in bits [i*QW +: QW] |
| in_rank | input | N_IN*IW | Per-input rank, lower wins ties |
| hyst_margin | input | QW | Quality margin required to displace a valid active input |
| holdoff_cyc | input | CW | Extra consecutive edges a quality improvement must persist |
| min_gap_cyc | input | CW | Minimum cycles between switches |
| force_en | input | 1 | Manual override enable |
| force_sel | input | IW | Input pinned by the override |
| active_sel | output | IW | Index of the active reference |
| no_ref | output | 1 | No input is valid |
| switch_stb | output | 1 | One-cycle pulse on each switch |
| evt_valid | output | 1 | Event present on `evt_reason` |
| evt_reason | output | 3 | 1 lost, 2 better quality, 3 manual, 4 deferred by rate limit |

## Verification
A wrong hold-off or run counter shows up as a quality switch one or more cycles early or late, so the bench compares `active_sel` and the strobe on every edge against a model. A stuck deferral flag shows as repeated reason-4 events or a missing one within the first cycle after a blocked switch. A wrong spacing counter shows as a switch arriving before or after the exact permitted edge, and a broken ranking shows on the very first loss-driven switch as the wrong index.

// File: rtl/ref_selector.sv
module ref_selector #(
  parameter int N_IN = 4,
  parameter int QW   = 4,
  parameter int CW   = 16,
  localparam int IW  = $clog2(N_IN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_IN-1:0]    in_valid,
  input  logic [N_IN*QW-1:0] in_qual,
  input  logic [N_IN*IW-1:0] in_rank,
  input  logic [QW-1:0]      hyst_margin,
  input  logic [CW-1:0]      holdoff_cyc,
  input  logic [CW-1:0]      min_gap_cyc,
  input  logic               force_en,
  input  logic [IW-1:0]      force_sel,
  output logic [IW-1:0]      active_sel,
  output logic               no_ref,
  output logic               switch_stb,
  output logic               evt_valid,
  output logic [2:0]         evt_reason
);
  localparam logic [2:0] RS_NONE = 3'd0, RS_LOST = 3'd1, RS_BETTER = 3'd2,
                         RS_MANUAL = 3'd3, RS_DEFER = 3'd4;
  localparam logic [CW-1:0] CMAX = '1;

  logic [IW-1:0] best_idx, run_cand, target;
  logic [QW-1:0] best_q;
  logic [IW-1:0] best_r;
  logic          any_v;
  logic [CW-1:0] since, run_cnt, eff_run;
  logic          defer_q;
  logic [2:0]    reason;

  always_comb begin
    best_idx = '0; best_q = '0; best_r = '0; any_v = 1'b0;
    for (int i = 0; i < N_IN; i++) begin
      if (in_valid[i] && (!any_v || in_qual[i*QW +: QW] > best_q ||
          (in_qual[i*QW +: QW] == best_q && in_rank[i*IW +: IW] < best_r))) begin
        any_v    = 1'b1;
        best_idx = IW'(i);
        best_q   = in_qual[i*QW +: QW];
        best_r   = in_rank[i*IW +: IW];
      end
    end
  end

  wire [QW-1:0] act_q   = in_qual[active_sel*QW +: QW];
  wire          act_v   = in_valid[active_sel];
  wire          better  = any_v && act_v &&
                          ({1'b0, best_q} > {1'b0, act_q} + {1'b0, hyst_margin});
  wire          lost    = any_v && !act_v;
  wire          pinned  = force_en && in_valid[force_sel];
  wire          frc     = pinned && (force_sel != active_sel);
  wire          run_hit = better && (best_idx == run_cand) && (run_cnt != '0);
  assign        eff_run = run_hit ? run_cnt : '0;
  wire          want_b  = !pinned && better && (eff_run >= holdoff_cyc);
  wire          want_l  = !pinned && lost;
  wire          want    = frc || want_l || want_b;
  wire          gap_ok  = since >= min_gap_cyc;
  wire          do_sw   = want && gap_ok;
  wire          defer   = want && !gap_ok && !defer_q;

  always_comb begin
    target = best_idx;
    reason = RS_BETTER;
    if (frc) begin
      target = force_sel;
      reason = RS_MANUAL;
    end else if (want_l) begin
      reason = RS_LOST;
    end
  end

  assign no_ref = !any_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_sel <= '0;
      switch_stb <= 1'b0;
      evt_valid  <= 1'b0;
      evt_reason <= RS_NONE;
      defer_q    <= 1'b0;
      since      <= CMAX;
      run_cnt    <= '0;
      run_cand   <= '0;
    end else begin
      switch_stb <= do_sw;
      evt_valid  <= do_sw || defer;
      evt_reason <= do_sw ? reason : (defer ? RS_DEFER : RS_NONE);
      defer_q    <= want && !gap_ok;
      run_cand   <= best_idx;
      if (do_sw) begin
        active_sel <= target;
        since      <= CW'(1);
        run_cnt    <= '0;
      end else begin
        if (since != CMAX) since <= since + 1'b1;
        if (!better)                run_cnt <= '0;
        else if (!run_hit)          run_cnt <= CW'(1);
        else if (run_cnt != CMAX)   run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  logic [CW-1:0] chk_gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_gap <= CMAX;
    else if (switch_stb) chk_gap <= CW'(1);
    else if (chk_gap != CMAX) chk_gap <= chk_gap + 1'b1;
  end

  // R9
  stb_has_reason_chk: assert property (@(posedge clk) disable iff (!rst_n)
    switch_stb |-> evt_valid && (evt_reason == RS_LOST || evt_reason == RS_BETTER ||
                                 evt_reason == RS_MANUAL));
  // R8
  noref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    no_ref |=> !switch_stb && $stable(active_sel));
  // R6
  min_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    switch_stb |-> chk_gap >= min_gap_cyc);
  // R6
  defer_no_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_reason == RS_DEFER) |-> !switch_stb);
  // R7
  manual_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (switch_stb && evt_reason == RS_MANUAL) |-> active_sel == $past(force_sel) && $past(force_en));
  // R9
  sel_changes_on_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !switch_stb |-> active_sel == $past(active_sel) || $past(!rst_n));
endmodule

// File: tb/ref_selector_tb.sv
module ref_selector_tb_top;
  localparam int N = 4, QW = 4, CW = 16, IW = 2;
  localparam int MARGIN = 2, HOLD = 3, GAP = 6;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic [N-1:0] vld = '0;
  int q[N], pr[N];
  logic fen = 0;
  logic [IW-1:0] fsel = 0;
  logic [N*QW-1:0] qual_bus;
  logic [N*IW-1:0] rank_bus;
  logic [IW-1:0] active_sel;
  logic no_ref, switch_stb, evt_valid;
  logic [2:0] evt_reason;

  always_comb for (int i = 0; i < N; i++) begin
    qual_bus[i*QW +: QW] = QW'(q[i]);
    rank_bus[i*IW +: IW] = IW'(pr[i]);
  end

  ref_selector #(.N_IN(N), .QW(QW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_qual(qual_bus), .in_rank(rank_bus),
    .hyst_margin(QW'(MARGIN)), .holdoff_cyc(CW'(HOLD)), .min_gap_cyc(CW'(GAP)),
    .force_en(fen), .force_sel(fsel), .active_sel(active_sel), .no_ref(no_ref),
    .switch_stb(switch_stb), .evt_valid(evt_valid), .evt_reason(evt_reason));

  int errs = 0, checks = 0;
  string cur_req = "R1";
  int m_act = 0, m_since = 65535, m_run = 0, m_cand = 0, m_defer = 0;
  int e_stb = 0, e_ev = 0, e_rsn = 0;

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int bi = 0, bq = 0, bp = 0, any = 0, eff, want = 0, tgt = 0, rsn = 0;
    bit better, lost, pin, frc, wl, wb, gap_ok, do_sw, dfr;
    for (int i = 0; i < N; i++)
      if (vld[i] && (any == 0 || q[i] > bq || (q[i] == bq && pr[i] < bp))) begin
        any = 1; bi = i; bq = q[i]; bp = pr[i];
      end
    better = any && vld[m_act] && (bq > q[m_act] + MARGIN);
    lost   = any && !vld[m_act];
    pin    = fen && vld[fsel];
    frc    = pin && (int'(fsel) != m_act);
    eff    = (better && bi == m_cand && m_run > 0) ? m_run : 0;
    wb     = !pin && better && eff >= HOLD;
    wl     = !pin && lost;
    want   = frc || wl || wb;
    tgt    = frc ? int'(fsel) : bi;
    rsn    = frc ? 3 : (wl ? 1 : 2);
    gap_ok = m_since >= GAP;
    do_sw  = want && gap_ok;
    dfr    = want && !gap_ok && !m_defer;
    e_stb  = do_sw;
    e_ev   = do_sw || dfr;
    e_rsn  = do_sw ? rsn : (dfr ? 4 : 0);
    m_defer = want && !gap_ok;
    m_cand = bi;
    if (do_sw) begin
      m_act = tgt; m_since = 1; m_run = 0;
    end else begin
      if (m_since < 65535) m_since++;
      if (!better) m_run = 0;
      else if (!(bi == m_cand && m_run > 0) && !(eff > 0)) m_run = 1;
      else if (m_run < 65535) m_run++;
    end
  endtask

  task automatic step();
    bit nr;
    model_step();
    @(posedge clk); #1;
    nr = (vld == '0);
    chk(cur_req, active_sel, m_act, "active_sel");
    chk(cur_req, switch_stb, e_stb, "switch_stb");
    chk(cur_req, evt_valid, e_ev, "evt_valid");
    if (e_ev) chk(cur_req, evt_reason, e_rsn, "evt_reason");
    chk("R8", no_ref, nr, "no_ref");
  endtask

  initial begin
    #400000;
    errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int defers, switched;
    for (int i = 0; i < N; i++) begin q[i] = 5; pr[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    chk("R1", active_sel, 0, "reset active_sel");
    chk("R1", switch_stb, 0, "reset switch_stb");
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk("R1", active_sel, 0, "post-reset active_sel");
    chk("R1", evt_valid, 0, "post-reset evt_valid");
    chk("R8", no_ref, 1, "no_ref with nothing valid");

    // R2/R5: loss of input 0, tie on grade broken by rank
    cur_req = "R5";
    vld = 4'b0110; q[1] = 7; q[2] = 7; pr[1] = 2; pr[2] = 1; q[3] = 3;
    step();
    chk("R2", active_sel, 2, "rank tie-break pick");
    chk("R5", evt_reason, 1, "lost reason");
    repeat (8) step();

    // R3: inside the margin, no switch
    cur_req = "R3";
    vld = 4'b1110; q[3] = 9;
    repeat (10) step();
    chk("R3", active_sel, 2, "margin not exceeded");

    // R4: hold-off timing
    cur_req = "R4";
    q[3] = 10;
    repeat (HOLD) step();
    chk("R4", active_sel, 2, "before hold-off expiry");
    step();
    chk("R4", active_sel, 3, "at hold-off expiry");
    chk("R4", evt_reason, 2, "better reason");

    // R6: loss right after a switch is deferred once
    cur_req = "R6";
    vld = 4'b0110;
    defers = 0; switched = 0;
    for (int k = 0; k < 10; k++) begin
      step();
      if (evt_valid && evt_reason == 3'd4) defers++;
      if (switch_stb) switched = k + 1;
    end
    chk("R6", defers, 1, "single deferral event");
    chk("R6", switched, GAP, "switch at spacing limit");
    chk("R6", active_sel, 2, "deferred target");

    // R7: manual override
    cur_req = "R7";
    repeat (8) step();
    vld = 4'b0111; q[0] = 3; fen = 1; fsel = 0;
    step();
    chk("R7", active_sel, 0, "forced input");
    chk("R7", evt_reason, 3, "manual reason");
    q[1] = 15;
    repeat (10) step();
    chk("R7", active_sel, 0, "no auto switch while pinned");
    fen = 0;
    repeat (8) step();
    chk("R4", active_sel, 1, "auto resumes after release");

    // R7: forced input invalid falls back to automatic rules
    fen = 1; fsel = 3;
    repeat (8) step();
    fen = 0;

    // R8: nothing valid
    cur_req = "R8";
    vld = '0;
    repeat (5) step();
    chk("R8", active_sel, 1, "selection kept");
    chk("R8", no_ref, 1, "no_ref raised");
    cur_req = "R5";
    vld = 4'b0100;
    repeat (3) step();
    chk("R5", active_sel, 2, "recover from no reference");

    cur_req = "R9";
    repeat (5) step();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule